// File: doc/BRIEF.md
# Byte-Lane Load/Store Steering Unit

This block connects a 32-bit processor load/store port to a word-organised data memory whose locations are addressed per byte. A request carries a byte address, a size (single byte or whole word), a direction (load or store), a signedness flag for byte loads and a byte-order select. The block turns each request into a word-aligned memory address. For stores it also produces write data already placed on the correct byte lane, together with per-lane write enables.

On loads the block takes the memory word back in the same cycle as the request. It selects the addressed byte and extends it, or it passes the whole word through unchanged. The result is registered. The byte order is chosen at run time and affects only byte accesses; a whole word reads and writes the same 32-bit value in either order. A word request whose address is not a multiple of four is refused with an error flag.

Top module: `lsu_lane_steer`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two least significant bits forced to zero, for every request.
- R2: An aligned word store drives `st_data` unchanged on `mem_wdata` and sets `mem_be` to 4'b1111 in both byte orders.
- R3: In little-endian order (`big_endian`=0), a byte store uses lane `req_addr[1:0]`, where lane k is bits 8k+7:8k. `mem_be` has only bit k set, and `mem_wdata` carries `st_data[7:0]` repeated on all four lanes.
- R4: In big-endian order (`big_endian`=1), a byte store uses lane 3-`req_addr[1:0]`, so byte 0 of a word lands in bits 31:24. `mem_be` has only that lane's bit set.
- R5: A load request returns its result on `ld_data` with `ld_valid` high exactly one clock after the request cycle. An aligned word load returns the memory word unchanged in both byte orders. `ld_valid` is low in any cycle that does not follow a load request.
- R6: A byte load selects its lane from `req_addr[1:0]` using the same mapping as R3 in little-endian order and as R4 in big-endian order.
- R7: A byte load with `req_signed`=1 sign-extends the selected byte to 32 bits. With `req_signed`=0 it zero-extends the byte.
- R8: A word request with `req_addr[1:0]` nonzero raises `misalign` in the request cycle and holds `mem_be` at zero, so memory is not written. If the request is a load, `ld_data` is zero when `ld_valid` rises.
- R9: After reset, `ld_valid` is 0 and `ld_data` is 0.
- R10: A byte request never raises `misalign`, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_signed | input | 1 | Byte loads: 1 = sign-extend, 0 = zero-extend |
| big_endian | input | 1 | Byte order: 1 = big-endian, 0 = little-endian |
| req_addr | input | 32 | Byte address |
| st_data | input | 32 | Store data (byte stores use bits 7:0) |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd | output | 1 | Memory read strobe for accepted loads |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_be | output | 4 | Per-lane write enables |
| mem_rdata | input | 32 | Memory read word, valid in the request cycle |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Misaligned word request |

## Verification
The hardest case to reach from the ports is a refused access that must leave no trace. A misaligned word store has to leave memory untouched, and the only way to see that is a later aligned read of the word it would have hit. The stimulus therefore writes a known pattern first, then issues the misaligned store, then reads the word back in a later load. Byte lanes are checked by building one known word and reading every lane position in both byte orders. The byte values are chosen so that sign extension and zero extension give different results.

// File: rtl/lane_pkg.sv
// lane_pkg: shared constants and the byte-order encoding used by the
// load/store steering unit. Assumes 8-bit bytes.
package lane_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;

endpackage

// File: rtl/lane_decode.sv
// lane_decode: maps the low address bits to a byte lane for the selected
// byte order and flags word requests that are not word aligned.
// Assumes LANES is a power of two and LW = log2(LANES).
module lane_decode #(
    parameter int LANES = 4,
    parameter int LW    = 2
) (
    input  logic [LW-1:0]    addr_lo,
    input  logic             big_endian,
    input  logic             is_word,
    output logic [LW-1:0]    lane,
    output logic [LANES-1:0] lane_hot,
    output logic             misalign
);
    import lane_pkg::*;

    byte_order_e order;

    // Interpret the order select as the package encoding.
    always_comb order = byte_order_e'(big_endian);

    // Big-endian counts lanes from the top, little-endian from the bottom.
    always_comb begin
        if (order == ORDER_BIG)
            lane = LW'(LANES - 1) - addr_lo;
        else
            lane = addr_lo;
    end

    // One-hot decode of the chosen lane.
    for (genvar i = 0; i < LANES; i++) begin : g_hot
        assign lane_hot[i] = (lane == LW'(i));
    end

    // Only word accesses have an alignment constraint.
    always_comb misalign = is_word && (addr_lo != '0);

endmodule

// File: rtl/store_steer.sv
// store_steer: builds lane-placed write data and byte enables for a store.
// Assumes lane_hot is one-hot whenever a byte store is active.
module store_steer #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              active,
    input  logic              is_word,
    input  logic [LANES-1:0]  lane_hot,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be
);
    import lane_pkg::*;

    // Word: pass each lane through; byte: repeat the low byte on every lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wdata[i*BYTE_W +: BYTE_W] =
            is_word ? st_data[i*BYTE_W +: BYTE_W] : st_data[BYTE_W-1:0];
    end

    // Enables: all lanes for a word, the decoded lane for a byte, none when idle.
    always_comb begin
        if (!active)
            be = '0;
        else if (is_word)
            be = '1;
        else
            be = lane_hot;
    end

    // R3/R4: a byte store touches exactly one lane.
    always_comb begin
        if (active && !is_word)
            a_r3_single_lane: assert ($countones(be) == 1);
    end

endmodule

// File: rtl/load_extract.sv
// load_extract: registers the load result one clock after the request,
// selecting and extending a byte or passing the word through.
// Assumes rdata is valid in the cycle capture is high.
module load_extract #(
    parameter int DATA_W = 32,
    parameter int LW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              is_word,
    input  logic              is_signed,
    input  logic              misalign,
    input  logic [LW-1:0]     lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_valid
);
    import lane_pkg::*;

    logic [BYTE_W-1:0] sel_byte;
    logic [DATA_W-1:0] ext_byte;
    logic [DATA_W-1:0] next_data;

    // Pick the addressed byte from the memory word.
    always_comb sel_byte = rdata[{lane, 3'b000} +: BYTE_W];

    // Sign- or zero-extend the byte to the full width.
    always_comb ext_byte = {{(DATA_W-BYTE_W){is_signed & sel_byte[BYTE_W-1]}}, sel_byte};

    // Choose between refused, whole word and extended byte.
    always_comb begin
        if (misalign)
            next_data = '0;
        else if (is_word)
            next_data = rdata;
        else
            next_data = ext_byte;
    end

    // Result register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= capture;
            if (capture)
                ld_data <= next_data;
        end
    end

    // R5: every capture is followed by a valid result.
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ld_valid);

endmodule

// File: rtl/lsu_lane_steer.sv
// lsu_lane_steer: top of the byte-lane load/store steering unit. Aligns the
// memory address, steers store lanes, extracts load bytes with run-time byte
// order, and refuses misaligned word requests.
// Assumes a memory whose read data is valid combinationally in the request cycle.
module lsu_lane_steer #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_word,
    input  logic              req_signed,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W/8-1:0] mem_be,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              misalign
);
    localparam int LANES = DATA_W / 8;
    localparam int LW    = $clog2(LANES);

    logic [LW-1:0]    lane;
    logic [LANES-1:0] lane_hot;
    logic             mis_raw;
    logic             st_go;
    logic             ld_go;

    // Clear the lane bits to form the word address.
    always_comb mem_addr = {req_addr[ADDR_W-1:LW], {LW{1'b0}}};

    // Qualify the raw alignment flag with a live request.
    always_comb misalign = req_valid && mis_raw;

    // Accepted stores and loads (loads are captured even when refused).
    always_comb st_go  = req_valid && req_store && !mis_raw;
    always_comb ld_go  = req_valid && !req_store;
    always_comb mem_rd = ld_go && !mis_raw;

    lane_decode #(.LANES(LANES), .LW(LW)) u_dec (
        .addr_lo   (req_addr[LW-1:0]),
        .big_endian(big_endian),
        .is_word   (req_word),
        .lane      (lane),
        .lane_hot  (lane_hot),
        .misalign  (mis_raw)
    );

    store_steer #(.DATA_W(DATA_W), .LANES(LANES)) u_st (
        .active  (st_go),
        .is_word (req_word),
        .lane_hot(lane_hot),
        .st_data (st_data),
        .wdata   (mem_wdata),
        .be      (mem_be)
    );

    load_extract #(.DATA_W(DATA_W), .LW(LW)) u_ld (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (ld_go),
        .is_word  (req_word),
        .is_signed(req_signed),
        .misalign (mis_raw),
        .lane     (lane),
        .rdata    (mem_rdata),
        .ld_data  (ld_data),
        .ld_valid (ld_valid)
    );

    // R8: a refused request never writes memory.
    a_r8_no_write_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == '0));

    // R8: a refused load returns zero.
    a_r8_zero_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && misalign) |=> (ld_data == '0));

    // R10: byte requests are never refused.
    a_r10_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_word) |-> !misalign);

    // R5: a result appears only after a load request.
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_store) |=> !ld_valid);

    // R2: an aligned word store enables every lane.
    a_r2_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_word && !misalign) |-> (mem_be == '1));

endmodule

// File: tb/lsu_lane_steer_tb.sv
module lsu_lane_steer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_word, req_signed, big_endian;
    logic [31:0] req_addr, st_data;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
    logic [3:0]  mem_be;
    logic        mem_rd, ld_valid, misalign;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] mem [16];

    always #10 clk = ~clk;

    lsu_lane_steer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_word(req_word), .req_signed(req_signed), .big_endian(big_endian),
        .req_addr(req_addr), .st_data(st_data), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
        .misalign(misalign)
    );

    // Memory model: combinational read, per-lane write on the clock.
    assign mem_rdata = mem[mem_addr[5:2]];
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (mem_be[i]) mem[mem_addr[5:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_store = 0; req_word = 0; req_signed = 0;
        req_addr = 0; st_data = 0;
    endtask

    // Issue a store at a negedge; check lane outputs before the write edge.
    task automatic store(input logic [31:0] a, input logic [31:0] d,
                         input logic w, input logic be_ord,
                         input logic [3:0] exp_be, input logic [31:0] exp_wd,
                         input logic exp_mis, input string req);
        @(negedge clk);
        req_valid = 1; req_store = 1; req_word = w; big_endian = be_ord;
        req_addr = a; st_data = d;
        #2;
        check({req, " be"}, {28'd0, mem_be}, {28'd0, exp_be});
        if (!exp_mis) check({req, " wdata"}, mem_wdata, exp_wd);
        check({req, " misalign"}, {31'd0, misalign}, {31'd0, exp_mis});
        check("R1 mem_addr", mem_addr, {a[31:2], 2'b00});
        @(negedge clk);
        idle();
    endtask

    // Issue a load; check the registered result one clock later.
    task automatic load(input logic [31:0] a, input logic w, input logic sg,
                        input logic be_ord, input logic [31:0] exp,
                        input logic exp_mis, input string req);
        @(negedge clk);
        req_valid = 1; req_store = 0; req_word = w; req_signed = sg;
        big_endian = be_ord; req_addr = a;
        #2;
        check({req, " misalign"}, {31'd0, misalign}, {31'd0, exp_mis});
        @(negedge clk);
        check({req, " valid"}, {31'd0, ld_valid}, 32'd1);
        check({req, " data"}, ld_data, exp);
        idle();
        @(negedge clk);
        check("R5 valid drops", {31'd0, ld_valid}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 ld_valid", {31'd0, ld_valid}, 32'd0);
        check("R9 ld_data", ld_data, 32'd0);
    endtask

    task automatic t_word();
        store(32'h8, 32'hA1B2C3D4, 1, 0, 4'hF, 32'hA1B2C3D4, 0, "R2 le");
        store(32'hC, 32'h1234567F, 1, 1, 4'hF, 32'h1234567F, 0, "R2 be");
        load(32'h8, 1, 0, 0, 32'hA1B2C3D4, 0, "R5 word le");
        load(32'h8, 1, 0, 1, 32'hA1B2C3D4, 0, "R5 word be");
    endtask

    task automatic t_byte_store();
        store(32'h10, 32'h0, 1, 0, 4'hF, 32'h0, 0, "R2 clear");
        store(32'h11, 32'hFFFF005A, 0, 0, 4'b0010, 32'h5A5A5A5A, 0, "R3 le lane1");
        store(32'h10, 32'h00000077, 0, 1, 4'b1000, 32'h77777777, 0, "R4 be lane3");
        store(32'h13, 32'h00000033, 0, 1, 4'b0001, 32'h33333333, 0, "R4 be lane0");
        load(32'h10, 1, 0, 0, 32'h77005A33, 0, "R3 R4 memory image");
    endtask

    task automatic t_byte_load();
        load(32'h8, 0, 1, 0, 32'hFFFFFFD4, 0, "R6 R7 le a0 signed");
        load(32'h8, 0, 0, 0, 32'h000000D4, 0, "R7 le a0 unsigned");
        load(32'h8, 0, 1, 1, 32'hFFFFFFA1, 0, "R6 R7 be a0 signed");
        load(32'hA, 0, 0, 0, 32'h000000B2, 0, "R6 le a2");
        load(32'hA, 0, 0, 1, 32'h000000C3, 0, "R6 be a2");
        load(32'hC, 0, 1, 0, 32'h0000007F, 0, "R7 signed positive");
        load(32'hF, 0, 1, 1, 32'h0000007F, 0, "R6 be a3");
    endtask

    task automatic t_misalign();
        store(32'h4, 32'h11111111, 1, 0, 4'hF, 32'h11111111, 0, "R2 prep");
        store(32'h6, 32'hDEADBEEF, 1, 0, 4'h0, 32'h0, 1, "R8 store");
        load(32'h4, 1, 0, 0, 32'h11111111, 0, "R8 memory untouched");
        load(32'h9, 1, 0, 0, 32'h0, 1, "R8 load zero");
        load(32'h9, 0, 0, 0, 32'h000000C3, 0, "R10 byte at odd addr");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        idle(); big_endian = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_word();
        t_byte_store();
        t_byte_load();
        t_misalign();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule